// File: doc/BRIEF.md
# Pad-routed SPI slave with address filter

This block is a serial-peripheral slave that runs entirely on the system clock. It oversamples the serial clock, the select line and the incoming data through short synchronizer chains, and it finds serial clock edges by comparing successive samples. The clock polarity and clock phase inputs give the four usual timing modes. Each of the three input signals and the one output signal can sit on any of four pads. The data-out selection fixes the pads for the output, the clock and the select, and the data-in selection fixes the pad for incoming data.

Frames carry 8-bit bytes, most significant bit first. Each received byte appears as a one-cycle strobe with its data. The byte to send is taken from a transmit port when select asserts and again each time a byte completes. In the addressed format, the first byte of a frame is compared with a programmed address. On a match, that byte is swallowed and the rest of the frame is delivered. On a mismatch, the whole frame is ignored and the output pad is released.

The configuration inputs are treated as unsynchronized. They are captured only while the enable is low and are held while it is high.

Top module: `spi_addr_slave`

## Requirements
- R1: After reset, rx_valid is 0 and all pad_oe bits are 0.
- R2: All four timing modes work. With cpol=0 the leading edge is rising; with cpol=1 it is falling. With cpha=0 data is sampled on the leading edge; with cpha=1 it is sampled on the trailing edge. Bytes are assembled MSB first.
- R3: The transmit byte is captured when select goes low and is shifted out MSB first on the non-sampling edge. With cpha=0, its MSB is on the output pad before the first clock edge. Later bytes of the frame use tx_data as sampled at the completion of the previous byte.
- R4: The data-out selection maps pads as {out, clock, select}: 0 gives {0,1,2}, 1 gives {2,3,1}, 2 gives {3,1,2}, 3 gives {0,3,1}. Only the output pad has its enable set, and only while select is low.
- R5: The data-in selection value n takes incoming data from pad n.
- R6: A format value of 0, or any value other than 2, is a plain frame: every complete byte is reported on rx_valid/rx_data.
- R7: With format 2, a first byte equal to cfg_addr is not reported, and the following bytes of the frame are reported.
- R8: With format 2, a first byte not equal to cfg_addr causes no byte of the frame to be reported. The output pad enable stays 0 from then until select goes high.
- R9: Raising select in the middle of a byte discards the partial bits. The next frame starts counting from bit 0.
- R10: If the data-in pad equals the output, clock or select pad of the data-out selection, the block stays idle: no rx_valid and no pad enable.
- R11: Configuration inputs change the behaviour only while cfg_en is low. Changes made while cfg_en is high have no effect.
- R12: rx_valid is high for exactly one system clock per byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | 4 | Level seen on each pad |
| pad_o | output | 4 | Value driven onto each pad |
| pad_oe | output | 4 | Output enable for each pad |
| cfg_en | input | 1 | Enable; configuration is captured while low |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_form | input | 4 | Frame format, 2 = addressed, others plain |
| cfg_di_sel | input | 2 | Pad number for incoming data |
| cfg_do_sel | input | 2 | Pad set for output, clock and select |
| cfg_addr | input | 8 | Address compared with the first byte |
| tx_data | input | 8 | Byte to transmit |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |

## Verification
Frames are driven in each of the four timing modes, each with a different pad routing. A wrong edge choice, a swapped pad or a reversed bit order therefore shows up as corrupted receive bytes or a corrupted output byte. Addressed frames are sent with a matching first byte, with a mismatching one, and then with a matching one again. These separate correct filtering from a drop condition that lingers across frames. Further tests cover a truncated byte followed by a full frame, a conflicting pad choice, a reserved format code, and configuration changes made while enabled. These show, in order, that the bit count restarts with each frame, that a conflicting configuration keeps the block idle, that reserved codes behave as plain frames, and that configuration is held while enabled.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  localparam int NPAD = 4;
  localparam logic [3:0] FORM_ADDRESSED = 4'h2;

  typedef logic [1:0] pad_idx_t;

  typedef struct packed {
    logic     cpol;
    logic     cpha;
    logic [3:0] form;
    pad_idx_t di_sel;
    pad_idx_t do_sel;
  } slv_cfg_t;

  typedef struct packed {
    pad_idx_t dout;
    pad_idx_t sck;
    pad_idx_t ss;
  } pad_map_t;

  function automatic pad_map_t map_pads(input pad_idx_t sel);
    pad_map_t m;
    case (sel)
      2'd0:    m = '{dout: 2'd0, sck: 2'd1, ss: 2'd2};
      2'd1:    m = '{dout: 2'd2, sck: 2'd3, ss: 2'd1};
      2'd2:    m = '{dout: 2'd3, sck: 2'd1, ss: 2'd2};
      default: m = '{dout: 2'd0, sck: 2'd3, ss: 2'd1};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int             WIDTH   = 3,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_slv_cfg.sv
module spi_slv_cfg
  import spi_slv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_en,
  input  slv_cfg_t   cfg_in,
  input  logic [W-1:0] addr_in,
  output slv_cfg_t   cfg_q,
  output logic [W-1:0] addr_q,
  output pad_map_t   pmap,
  output logic       addr_mode,
  output logic       cfg_err
);

  slv_cfg_t      cfg_d;
  logic [W-1:0]  addr_d;

  // capture only while disabled; hold while running
  always_comb begin
    cfg_d  = cfg_q;
    addr_d = addr_q;
    if (!cfg_en) begin
      cfg_d  = cfg_in;
      addr_d = addr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      addr_q <= addr_d;
    end
  end

  always_comb begin
    pmap      = map_pads(cfg_q.do_sel);
    addr_mode = (cfg_q.form == FORM_ADDRESSED);
    cfg_err   = (cfg_q.di_sel == pmap.dout) ||
                (cfg_q.di_sel == pmap.sck)  ||
                (cfg_q.di_sel == pmap.ss);
  end

endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         addr_mode,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] tx_data,
  input  logic         sck_s,
  input  logic         ss_n_s,
  input  logic         mosi_s,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  output logic         miso,
  output logic         miso_oe,
  output logic         drop
);

  localparam int            CW   = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          in_frame_q, in_frame_d;
  logic          sck_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  rx_sh_q, rx_sh_d;
  logic [W-1:0]  tx_sh_q, tx_sh_d;
  logic [W-1:0]  hold_q, hold_d;
  logic          miso_q, miso_d;
  logic          addr_ph_q, addr_ph_d;
  logic          drop_q, drop_d;
  logic          vld_q, vld_d;
  logic [W-1:0]  data_q, data_d;

  logic sel, start, run;
  logic rise, fall, lead, trail, smp, shf;
  logic [W-1:0] byte_w;

  always_comb begin
    sel   = active & ~ss_n_s;
    start = sel & ~in_frame_q;
    run   = sel & in_frame_q;
    rise  = sck_s & ~sck_q;
    fall  = ~sck_s & sck_q;
    lead  = cpol ? fall : rise;
    trail = cpol ? rise : fall;
    smp   = run & (cpha ? trail : lead);
    shf   = run & (cpha ? lead : trail);
    byte_w = {rx_sh_q[W-2:0], mosi_s};
  end

  always_comb begin
    in_frame_d = sel;
    cnt_d      = cnt_q;
    rx_sh_d    = rx_sh_q;
    tx_sh_d    = tx_sh_q;
    hold_d     = hold_q;
    miso_d     = miso_q;
    addr_ph_d  = addr_ph_q;
    drop_d     = drop_q;
    vld_d      = 1'b0;
    data_d     = data_q;
    if (!sel) begin
      cnt_d     = '0;
      addr_ph_d = 1'b0;
      drop_d    = 1'b0;
    end else if (start) begin
      cnt_d     = '0;
      addr_ph_d = addr_mode;
      drop_d    = 1'b0;
      hold_d    = tx_data;
      miso_d    = tx_data[W-1];
      tx_sh_d   = tx_data << 1;
    end else begin
      if (smp) begin
        rx_sh_d = byte_w;
        if (cnt_q == LAST) begin
          cnt_d  = '0;
          hold_d = tx_data;
          if (addr_ph_q) begin
            addr_ph_d = 1'b0;
            drop_d    = (byte_w != addr);
          end else if (!drop_q) begin
            vld_d  = 1'b1;
            data_d = byte_w;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (shf) begin
        if (cnt_q == '0) begin
          miso_d  = hold_q[W-1];
          tx_sh_d = hold_q << 1;
        end else begin
          miso_d  = tx_sh_q[W-1];
          tx_sh_d = tx_sh_q << 1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      sck_q      <= 1'b0;
      cnt_q      <= '0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      hold_q     <= '0;
      miso_q     <= 1'b0;
      addr_ph_q  <= 1'b0;
      drop_q     <= 1'b0;
      vld_q      <= 1'b0;
      data_q     <= '0;
    end else begin
      in_frame_q <= in_frame_d;
      sck_q      <= sck_s;
      cnt_q      <= cnt_d;
      rx_sh_q    <= rx_sh_d;
      tx_sh_q    <= tx_sh_d;
      hold_q     <= hold_d;
      miso_q     <= miso_d;
      addr_ph_q  <= addr_ph_d;
      drop_q     <= drop_d;
      vld_q      <= vld_d;
      data_q     <= data_d;
    end
  end

  assign rx_valid = vld_q;
  assign rx_data  = data_q;
  assign miso     = miso_q;
  assign miso_oe  = in_frame_q & ~drop_q;
  assign drop     = drop_q;

endmodule

// File: rtl/spi_addr_slave.sv
module spi_addr_slave
  import spi_slv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPAD-1:0]   pad_i,
  output logic [NPAD-1:0]   pad_o,
  output logic [NPAD-1:0]   pad_oe,
  input  logic              cfg_en,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [3:0]        cfg_form,
  input  logic [1:0]        cfg_di_sel,
  input  logic [1:0]        cfg_do_sel,
  input  logic [DATA_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  slv_cfg_t          cfg_in_w, cfg_word_q;
  logic [DATA_W-1:0] addr_q;
  pad_map_t          pmap;
  logic              addr_mode, cfg_err_w;

  assign cfg_in_w = '{cpol: cfg_cpol, cpha: cfg_cpha, form: cfg_form,
                      di_sel: cfg_di_sel, do_sel: cfg_do_sel};

  spi_slv_cfg #(.W(DATA_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .cfg_en    (cfg_en),
    .cfg_in    (cfg_in_w),
    .addr_in   (cfg_addr),
    .cfg_q     (cfg_word_q),
    .addr_q    (addr_q),
    .pmap      (pmap),
    .addr_mode (addr_mode),
    .cfg_err   (cfg_err_w)
  );

  // pad selection into the synchronizer: {ss_n, sck, mosi}
  logic [2:0] raw_w, syn_w;
  assign raw_w = {pad_i[pmap.ss], pad_i[pmap.sck], pad_i[cfg_word_q.di_sel]};

  spi_slv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d     (raw_w),
    .q     (syn_w)
  );

  logic active_w, miso_w, miso_oe_w, drop_w;
  assign active_w = cfg_en & ~cfg_err_w;

  spi_slv_core #(.W(DATA_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .active    (active_w),
    .cpol      (cfg_word_q.cpol),
    .cpha      (cfg_word_q.cpha),
    .addr_mode (addr_mode),
    .addr      (addr_q),
    .tx_data   (tx_data),
    .sck_s     (syn_w[1]),
    .ss_n_s    (syn_w[2]),
    .mosi_s    (syn_w[0]),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .miso      (miso_w),
    .miso_oe   (miso_oe_w),
    .drop      (drop_w)
  );

  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    logic is_out;
    assign is_out    = (pmap.dout == pad_idx_t'(p));
    assign pad_oe[p] = miso_oe_w & is_out;
    assign pad_o[p]  = miso_w & is_out;
  end

endmodule

// File: rtl/spi_slv_chk.sv
module spi_slv_chk #(
  parameter int NP = 4,
  parameter int CW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic [NP-1:0] pad_oe,
  input logic          cfg_en,
  input logic          cfg_err,
  input logic          drop,
  input logic [CW-1:0] cfg_word
);

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r4_one_pad_driven: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pad_oe));

  a_r10_conflict_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (pad_oe == '0) && !rx_valid);

  a_r8_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (pad_oe == '0) && !rx_valid);

  a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && $past(cfg_en)) |-> $stable(cfg_word));

endmodule

bind spi_addr_slave spi_slv_chk #(.NP(spi_slv_pkg::NPAD), .CW($bits(cfg_word_q) + DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_valid (rx_valid),
  .pad_oe   (pad_oe),
  .cfg_en   (cfg_en),
  .cfg_err  (cfg_err_w),
  .drop     (drop_w),
  .cfg_word ({cfg_word_q, addr_q})
);

// File: tb/sim_spi_addr_slave.sv
module sim_spi_addr_slave;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] drv;
  logic [3:0] pad_o, pad_oe;
  logic       cfg_en, cfg_cpol, cfg_cpha;
  logic [3:0] cfg_form;
  logic [1:0] cfg_di_sel, cfg_do_sel;
  logic [7:0] cfg_addr, tx_data;
  logic       rx_valid;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  spi_addr_slave u0 (
    .clk(clk), .rst_n(rst_n), .pad_i(drv), .pad_o(pad_o), .pad_oe(pad_oe),
    .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_form(cfg_form),
    .cfg_di_sel(cfg_di_sel), .cfg_do_sel(cfg_do_sel), .cfg_addr(cfg_addr),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R6";
  logic [7:0] exp_q[$];

  // bench model of the active configuration
  logic m_cpol, m_cpha, m_addr_fmt, m_conflict;
  logic [7:0] m_addr;
  int do_p, sck_p, ss_p, di_p;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  logic prev_vld = 1'b0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (rx_valid && prev_vld)
        check(1'b0, "R12", "strobe longer than one cycle", 2, 1);
      if (rx_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected byte", {24'h0, rx_data}, 32'hFFFF);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rx_data == e, cur_req, "received byte", {24'h0, rx_data}, {24'h0, e});
        end
      end
      prev_vld <= rx_valid;
    end
  end

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic configure(input logic cpol, input logic cpha, input logic [3:0] form,
                           input logic [1:0] dis, input logic [1:0] dos, input logic [7:0] adr);
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_form = form;
    cfg_di_sel = dis; cfg_do_sel = dos; cfg_addr = adr;
    m_cpol = cpol; m_cpha = cpha; m_addr_fmt = (form == 4'h2); m_addr = adr;
    case (dos)
      2'd0: begin do_p = 0; sck_p = 1; ss_p = 2; end
      2'd1: begin do_p = 2; sck_p = 3; ss_p = 1; end
      2'd2: begin do_p = 3; sck_p = 1; ss_p = 2; end
      default: begin do_p = 0; sck_p = 3; ss_p = 1; end
    endcase
    di_p = dis;
    m_conflict = (di_p == do_p) || (di_p == sck_p) || (di_p == ss_p);
    drv = 4'b0000;
    drv[sck_p] = cpol;
    drv[ss_p]  = 1'b1;
    repeat (4) @(negedge clk);
    cfg_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic mo, output logic mi, output logic oe, output logic other);
    if (!m_cpha) begin
      drv[di_p] = mo;
      wait_half();
      mi = pad_o[do_p]; oe = pad_oe[do_p]; other = |(pad_oe & ~(4'b1 << do_p));
      drv[sck_p] = ~drv[sck_p];
      wait_half();
      drv[sck_p] = ~drv[sck_p];
    end else begin
      drv[sck_p] = ~drv[sck_p];
      drv[di_p] = mo;
      wait_half();
      mi = pad_o[do_p]; oe = pad_oe[do_p]; other = |(pad_oe & ~(4'b1 << do_p));
      drv[sck_p] = ~drv[sck_p];
      wait_half();
    end
  endtask

  // one frame: pushes expectations, then checks MISO and output enables per byte
  task automatic frame(input int n, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input logic [7:0] tx, input string req);
    logic [7:0] bytes [3];
    bit dropped;
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    dropped = m_addr_fmt && (b0 != m_addr);
    cur_req = req;
    tx_data = tx;
    @(negedge clk);
    drv[ss_p] = 1'b0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] mi;
      bit all_oe, any_oe, any_other;
      all_oe = 1'b1; any_oe = 1'b0; any_other = 1'b0;
      if (!m_conflict && !(m_addr_fmt && k == 0) && !dropped)
        exp_q.push_back(bytes[k]);
      for (int i = 7; i >= 0; i--) begin
        logic b, e, o;
        bit_cycle(bytes[k][i], b, e, o);
        mi[i] = b;
        if (e) any_oe = 1'b1; else all_oe = 1'b0;
        if (o) any_other = 1'b1;
      end
      check(!any_other, "R4", "enable on a non-output pad", {31'h0, any_other}, 0);
      if (m_conflict) begin
        check(!any_oe, "R10", "output enabled with conflicting pads", {31'h0, any_oe}, 0);
      end else if (dropped && k > 0) begin
        check(!any_oe, "R8", "output enabled after address mismatch", {31'h0, any_oe}, 0);
      end else begin
        check(all_oe, "R4", "output pad enable during frame", {31'h0, all_oe}, 1);
        check(mi == tx, "R3", "transmitted byte", {24'h0, mi}, {24'h0, tx});
      end
    end
    wait_half();
    drv[ss_p] = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    check(exp_q.size() == 0, req, "bytes still expected after frame", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic partial(input int nbits);
    cur_req = "R9";
    @(negedge clk);
    drv[ss_p] = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      logic b, e, o;
      bit_cycle(1'b1, b, e, o);
    end
    wait_half();
    drv[ss_p] = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drv = 4'b0100;
    cfg_en = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_form = 4'h0;
    cfg_di_sel = 2'd3; cfg_do_sel = 2'd0; cfg_addr = 8'h00; tx_data = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(rx_valid == 1'b0, "R1", "rx_valid after reset", {31'h0, rx_valid}, 0);
    check(pad_oe == 4'h0, "R1", "pad_oe after reset", {28'h0, pad_oe}, 0);

    // R2 R5 R6: four modes, four routings
    configure(1'b0, 1'b0, 4'h0, 2'd3, 2'd0, 8'h00);
    frame(2, 8'hA5, 8'h3C, 8'h00, 8'hC7, "R2");
    configure(1'b0, 1'b1, 4'h0, 2'd0, 2'd1, 8'h00);
    frame(2, 8'h81, 8'h7E, 8'h00, 8'h5A, "R2");
    configure(1'b1, 1'b0, 4'h0, 2'd0, 2'd2, 8'h00);
    frame(2, 8'h0F, 8'hF0, 8'h00, 8'h96, "R5");
    configure(1'b1, 1'b1, 4'h0, 2'd2, 2'd3, 8'h00);
    frame(3, 8'h12, 8'h34, 8'hFE, 8'h69, "R2");

    // R6: reserved format code behaves as plain
    configure(1'b0, 1'b0, 4'h7, 2'd3, 2'd0, 8'h12);
    frame(2, 8'h12, 8'h55, 8'h00, 8'h3C, "R6");

    // R7 / R8: addressed frames
    configure(1'b0, 1'b0, 4'h2, 2'd3, 2'd0, 8'hA5);
    frame(3, 8'hA5, 8'h3C, 8'hC3, 8'hE1, "R7");
    frame(3, 8'h5A, 8'h11, 8'h22, 8'h1E, "R8");
    frame(2, 8'hA5, 8'h99, 8'h00, 8'h77, "R7");
    configure(1'b1, 1'b1, 4'h2, 2'd0, 2'd1, 8'h42);
    frame(3, 8'h43, 8'hAA, 8'hBB, 8'h24, "R8");
    frame(2, 8'h42, 8'hCD, 8'h00, 8'h24, "R7");

    // R9: truncated byte, then a full frame counted from bit 0
    configure(1'b0, 1'b0, 4'h0, 2'd3, 2'd0, 8'h00);
    partial(3);
    frame(1, 8'h6B, 8'h00, 8'h00, 8'hB6, "R9");

    // R10: data-in on the clock pad
    configure(1'b0, 1'b0, 4'h0, 2'd1, 2'd0, 8'h00);
    frame(2, 8'hFF, 8'h00, 8'h00, 8'hFF, "R10");

    // R11: change format and address while enabled; plain behaviour kept
    configure(1'b0, 1'b1, 4'h0, 2'd3, 2'd0, 8'h5A);
    @(negedge clk);
    cfg_form = 4'h2; cfg_addr = 8'h11; cfg_di_sel = 2'd1;
    frame(2, 8'h33, 8'h44, 8'h00, 8'h8E, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule